// File: doc/BRIEF.md
# Hardware Semaphore Lock Bank

This block is a bank of hardware mutex flags shared by several bus masters. Each master has its own simple register port. A request is presented for one cycle, and read data returns on the next cycle. A master claims a lock by reading that lock's word. If the lock was free, the read returns zero and the lock becomes taken within the same access. If the lock was already held, the read returns one and nothing changes. The holder frees the lock by writing zero to the same word.

A read-only word reports the size of the bank as a one-hot multiple of 32 locks. Software can therefore size the bank without prior knowledge. A debug output shows the taken/free flag of every lock. When two masters read the same free lock in the same cycle, a fixed priority picks the winner: the lowest-numbered port wins.

Top module: `lockbank_top`

## Requirements
- R1: After reset every lock is free, the debug state vector is all zero and every port's read data is zero.
- R2: A read of a free lock returns the word 0x00000000 on the following cycle and marks that lock taken.
- R3: A read of a taken lock returns the word 0x00000001 and leaves every lock unchanged.
- R4: A write of 0 to a lock word frees that lock. A write of any nonzero value to a lock word changes nothing.
- R5: Lock i sits at byte address 0x800 + 4*i. Address bits 11:10 equal 2'b10 select the lock page, bits 9:2 give the index, and bits 1:0 are ignored.
- R6: The size word sits at byte address 0x014 (bits 1:0 ignored). It reads as (NUM_LOCKS/32) shifted left by 24, so bits 27:24 are one-hot. Writes to it change nothing.
- R7: When several ports read the same free lock in one cycle, only the lowest-numbered of them gets 0. Every other port gets 1, and the lock ends taken.
- R8: A lock-page access whose index is at or above NUM_LOCKS reads as 0, claims nothing, and a write of 0 to it frees nothing.
- R9: A read of any address outside the lock page and the size word returns 0. A write there changes no lock.
- R10: Bit i of the debug state vector is 1 exactly when lock i is taken, and it reflects an access on the cycle after that access.
- R11: In one cycle, a write of 0 from one port and a read of the same taken lock from another port give the reader 1 and leave the lock free. Accesses from different ports to different locks in the same cycle take effect independently.
- R12: NUM_LOCKS is restricted to 32, 64, 128 or 256. Any other value is rejected at elaboration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| bus_req | input | NUM_PORTS | Per-port access request, one cycle per access |
| bus_we | input | NUM_PORTS | Per-port write enable (1 = write, 0 = read) |
| bus_addr | input | NUM_PORTS*12 | Per-port byte address, port p in bits 12p+11:12p |
| bus_wdata | input | NUM_PORTS*32 | Per-port write data, port p in bits 32p+31:32p |
| bus_rdata | output | NUM_PORTS*32 | Per-port read data, valid the cycle after a read, zero otherwise |
| lock_state | output | NUM_LOCKS | Debug vector, bit i set when lock i is taken |

## Verification
The bench builds the bank with three ports and 64 locks. With three ports, a three-way race on one free lock tests the whole priority order. It also allows a two-way race between the upper ports while port 0 is busy elsewhere, and a release racing a claim. With 64 locks, the size word reads 0x02000000. Indices 64 to 255 stay inside the lock page but fall outside the bank, so the out-of-range path is tested against real addresses. The highest lock, at 0x8FC, tests the top edge of the index range.

// File: rtl/lockbank_pkg.sv
package lockbank_pkg;

    localparam int ADDR_W    = 12;
    localparam int WORD_W    = 32;
    localparam int SLOT_W    = 8;
    localparam int LOCK_UNIT = 32;
    localparam int COUNT_LSB = 24;

    localparam logic [1:0]        LOCK_PAGE   = 2'b10;
    localparam logic [ADDR_W-3:0] SIZE_WORD_A = 10'h005;

    typedef enum logic [1:0] {
        RGN_OTHER  = 2'd0,
        RGN_SIZE   = 2'd1,
        RGN_LOCK   = 2'd2
    } region_e;

    typedef struct packed {
        region_e           region;
        logic [SLOT_W-1:0] slot;
    } target_t;

    // Decode a word address (byte address without bits 1:0).
    function automatic target_t classify(input logic [ADDR_W-3:0] word_a);
        target_t t;
        t.slot   = word_a[SLOT_W-1:0];
        t.region = RGN_OTHER;
        if (word_a[ADDR_W-3:ADDR_W-4] == LOCK_PAGE)
            t.region = RGN_LOCK;
        else if (word_a == SIZE_WORD_A)
            t.region = RGN_SIZE;
        return t;
    endfunction

    function automatic logic [WORD_W-1:0] size_word(input int n_locks);
        return WORD_W'(n_locks / LOCK_UNIT) << COUNT_LSB;
    endfunction

    function automatic bit legal_count(input int n_locks);
        return (n_locks == 32) || (n_locks == 64) ||
               (n_locks == 128) || (n_locks == 256);
    endfunction

endpackage

// File: rtl/lockbank_port_dec.sv
module lockbank_port_dec
    import lockbank_pkg::*;
#(
    parameter int NUM_LOCKS = 32,
    localparam int LIDX_W   = $clog2(NUM_LOCKS)
) (
    input  logic              req,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [WORD_W-1:0] wdata,
    output logic              rd_lock,
    output logic              rd_size,
    output logic              rd_zero,
    output logic              wr_release,
    output logic [LIDX_W-1:0] lidx
);

    target_t tgt;
    logic    in_bank;
    logic    unused_byte_sel;

    assign unused_byte_sel = ^addr[1:0];
    assign tgt     = classify(addr[ADDR_W-1:2]);
    assign in_bank = (tgt.region == RGN_LOCK) && (int'(tgt.slot) < NUM_LOCKS);
    assign lidx    = tgt.slot[LIDX_W-1:0];

    always_comb begin
        rd_lock    = 1'b0;
        rd_size    = 1'b0;
        rd_zero    = 1'b0;
        wr_release = 1'b0;
        if (req && !we) begin
            rd_lock = in_bank;
            rd_size = (tgt.region == RGN_SIZE);
            rd_zero = !in_bank && (tgt.region != RGN_SIZE);
        end
        if (req && we) begin
            wr_release = in_bank && (wdata == '0);
        end
    end

endmodule

// File: rtl/lockbank_claim_arb.sv
module lockbank_claim_arb #(
    parameter int NUM_PORTS = 2,
    parameter int NUM_LOCKS = 32,
    localparam int LIDX_W   = $clog2(NUM_LOCKS)
) (
    input  logic [NUM_PORTS-1:0]             rd_lock,
    input  logic [NUM_PORTS-1:0][LIDX_W-1:0] lidx,
    input  logic [NUM_LOCKS-1:0]             state,
    output logic [NUM_PORTS-1:0]             grant,
    output logic [NUM_LOCKS-1:0]             set_vec
);

    // Ports are visited in ascending order, so a claim made by a lower
    // port this cycle hides the lock from every higher port.
    always_comb begin
        grant   = '0;
        set_vec = '0;
        for (int p = 0; p < NUM_PORTS; p++) begin
            if (rd_lock[p] && !state[lidx[p]] && !set_vec[lidx[p]]) begin
                grant[p]         = 1'b1;
                set_vec[lidx[p]] = 1'b1;
            end
        end
    end

endmodule

// File: rtl/lockbank_state.sv
module lockbank_state #(
    parameter int NUM_PORTS = 2,
    parameter int NUM_LOCKS = 32,
    localparam int LIDX_W   = $clog2(NUM_LOCKS)
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic [NUM_LOCKS-1:0]             set_vec,
    input  logic [NUM_PORTS-1:0]             wr_release,
    input  logic [NUM_PORTS-1:0][LIDX_W-1:0] lidx,
    output logic [NUM_LOCKS-1:0]             state_q
);

    logic [NUM_LOCKS-1:0] clr_vec;

    always_comb begin
        clr_vec = '0;
        for (int p = 0; p < NUM_PORTS; p++) begin
            if (wr_release[p]) clr_vec[lidx[p]] = 1'b1;
        end
    end

    // A claim only happens on a free lock, so a same-cycle clear of that
    // lock would be a no-op on the old value; the claim wins.
    always_ff @(posedge clk) begin
        if (rst) state_q <= '0;
        else     state_q <= set_vec | (state_q & ~clr_vec);
    end

    // R1: reset frees every lock
    a_r1_reset_free: assert property (@(posedge clk) rst |=> (state_q == '0));

    // R7: the arbiter only ever claims a lock that is free
    a_r7_claim_only_free: assert property (@(posedge clk) disable iff (rst)
        ((set_vec & state_q) == '0));

    for (genvar i = 0; i < NUM_LOCKS; i++) begin : g_lock_chk
        // R3: a held lock stays held unless released
        a_r3_held_stays: assert property (@(posedge clk) disable iff (rst)
            (state_q[i] && !clr_vec[i]) |=> state_q[i]);
        // R4: a release of a held lock frees it
        a_r4_release_frees: assert property (@(posedge clk) disable iff (rst)
            (clr_vec[i] && !set_vec[i]) |=> !state_q[i]);
        // R10: a free lock with no claim stays free
        a_r10_free_stays: assert property (@(posedge clk) disable iff (rst)
            (!state_q[i] && !set_vec[i]) |=> !state_q[i]);
    end

endmodule

// File: rtl/lockbank_top.sv
module lockbank_top
    import lockbank_pkg::*;
#(
    parameter int NUM_PORTS = 2,
    parameter int NUM_LOCKS = 32
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [NUM_PORTS-1:0]        bus_req,
    input  logic [NUM_PORTS-1:0]        bus_we,
    input  logic [NUM_PORTS*ADDR_W-1:0] bus_addr,
    input  logic [NUM_PORTS*WORD_W-1:0] bus_wdata,
    output logic [NUM_PORTS*WORD_W-1:0] bus_rdata,
    output logic [NUM_LOCKS-1:0]        lock_state
);

    localparam int LIDX_W = $clog2(NUM_LOCKS);
    localparam logic [WORD_W-1:0] SIZE_VALUE = size_word(NUM_LOCKS);

    // R12: only one-hot multiples of 32 are accepted
    if (!legal_count(NUM_LOCKS)) begin : g_bad_count
        $error("lockbank_top: NUM_LOCKS must be 32, 64, 128 or 256");
    end

    logic [NUM_PORTS-1:0]             rd_lock;
    logic [NUM_PORTS-1:0]             rd_size;
    logic [NUM_PORTS-1:0]             rd_zero;
    logic [NUM_PORTS-1:0]             wr_release;
    logic [NUM_PORTS-1:0][LIDX_W-1:0] lidx;
    logic [NUM_PORTS-1:0]             grant;
    logic [NUM_LOCKS-1:0]             set_vec;
    logic [NUM_LOCKS-1:0]             state_q;
    logic [NUM_PORTS-1:0][WORD_W-1:0] rsp_d;
    logic [NUM_PORTS-1:0][WORD_W-1:0] rsp_q;

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        lockbank_port_dec #(.NUM_LOCKS(NUM_LOCKS)) u_dec (
            .req        (bus_req[p]),
            .we         (bus_we[p]),
            .addr       (bus_addr[p*ADDR_W +: ADDR_W]),
            .wdata      (bus_wdata[p*WORD_W +: WORD_W]),
            .rd_lock    (rd_lock[p]),
            .rd_size    (rd_size[p]),
            .rd_zero    (rd_zero[p]),
            .wr_release (wr_release[p]),
            .lidx       (lidx[p])
        );
    end

    lockbank_claim_arb #(.NUM_PORTS(NUM_PORTS), .NUM_LOCKS(NUM_LOCKS)) u_arb (
        .rd_lock (rd_lock),
        .lidx    (lidx),
        .state   (state_q),
        .grant   (grant),
        .set_vec (set_vec)
    );

    lockbank_state #(.NUM_PORTS(NUM_PORTS), .NUM_LOCKS(NUM_LOCKS)) u_state (
        .clk        (clk),
        .rst        (rst),
        .set_vec    (set_vec),
        .wr_release (wr_release),
        .lidx       (lidx),
        .state_q    (state_q)
    );

    always_comb begin
        for (int p = 0; p < NUM_PORTS; p++) begin
            rsp_d[p] = '0;
            if (rd_size[p])      rsp_d[p] = SIZE_VALUE;
            else if (rd_lock[p]) rsp_d[p] = {{(WORD_W-1){1'b0}}, !grant[p]};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) rsp_q <= '0;
        else     rsp_q <= rsp_d;
    end

    assign bus_rdata  = rsp_q;
    assign lock_state = state_q;

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port_chk
        // R2: a winning read returns zero and leaves the lock taken
        a_r2_claim_reads_zero: assert property (@(posedge clk) disable iff (rst)
            grant[p] |=> (rsp_q[p] == '0) && lock_state[$past(lidx[p])]);
        // R3: a read of a held lock returns one
        a_r3_held_reads_one: assert property (@(posedge clk) disable iff (rst)
            (rd_lock[p] && state_q[lidx[p]]) |=> (rsp_q[p] == WORD_W'(1)));
        // R6: the size word reads back the encoded count
        a_r6_size_value: assert property (@(posedge clk) disable iff (rst)
            rd_size[p] |=> (rsp_q[p] == SIZE_VALUE));
        // R8, R9: unmapped or out-of-bank reads return zero
        a_r9_unmapped_zero: assert property (@(posedge clk) disable iff (rst)
            rd_zero[p] |=> (rsp_q[p] == '0));
        for (genvar q = p + 1; q < NUM_PORTS; q++) begin : g_pair
            // R7: a higher port never wins a lock a lower port also reads
            a_r7_low_port_wins: assert property (@(posedge clk) disable iff (rst)
                !(grant[q] && rd_lock[p] && (lidx[p] == lidx[q])));
        end
    end

endmodule

// File: tb/lockbank_top_tb.sv
`timescale 1ns/1ps
module lockbank_top_tb;

    localparam int NP = 3;
    localparam int NL = 64;
    localparam int AW = 12;
    localparam int DW = 32;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #5 clk = ~clk;

    logic [NP-1:0]    req;
    logic [NP-1:0]    we;
    logic [NP*AW-1:0] addr;
    logic [NP*DW-1:0] wdata;
    logic [NP*DW-1:0] rdata;
    logic [NL-1:0]    lock_state;

    lockbank_top #(.NUM_PORTS(NP), .NUM_LOCKS(NL)) u_dut (
        .clk        (clk),
        .rst        (rst),
        .bus_req    (req),
        .bus_we     (we),
        .bus_addr   (addr),
        .bus_wdata  (wdata),
        .bus_rdata  (rdata),
        .lock_state (lock_state)
    );

    int checks   = 0;
    int failures = 0;
    logic [NL-1:0] model = '0;

    task automatic check_word(string tag, int port, logic [DW-1:0] act, logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s port%0d rdata actual=%h expected=%h", tag, port, act, exp);
        end
    endtask

    task automatic check_state(string tag, logic [NL-1:0] act, logic [NL-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s R10 lock_state actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic idle_all();
        req = '0; we = '0; addr = '0; wdata = '0;
    endtask

    task automatic put(int p, bit w, logic [AW-1:0] a, logic [DW-1:0] d);
        req[p] = 1'b1;
        we[p]  = w;
        addr[p*AW +: AW] = a;
        wdata[p*DW +: DW] = d;
    endtask

    // One bus cycle: predict, clock, compare, then clear the inputs.
    task automatic step(string tag);
        logic [DW-1:0] exp_rd [NP];
        logic [NL-1:0] claimed = '0;
        logic [NL-1:0] freed   = '0;
        for (int p = 0; p < NP; p++) begin
            int a = int'(addr[p*AW +: AW]);
            bit in_page = (a >= 'h800) && (a < 'hC00);
            int idx = (a - 'h800) / 4;
            exp_rd[p] = '0;
            if (req[p] && !we[p]) begin
                if ((a / 4) == ('h014 / 4))
                    exp_rd[p] = (NL / 32) * (1 << 24);
                else if (in_page && idx < NL) begin
                    if (model[idx] || claimed[idx]) exp_rd[p] = 1;
                    else claimed[idx] = 1'b1;
                end
            end
            if (req[p] && we[p] && in_page && idx < NL && wdata[p*DW +: DW] == 0)
                freed[idx] = 1'b1;
        end
        @(posedge clk);
        #1;
        model = claimed | (model & ~freed);
        for (int p = 0; p < NP; p++) check_word(tag, p, rdata[p*DW +: DW], exp_rd[p]);
        check_state(tag, lock_state, model);
        @(negedge clk);
        idle_all();
    endtask

    initial begin
        #2_000_000;
        checks++;
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        idle_all();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        step("R1 reset state");

        put(0, 0, 12'h800, 0);           step("R2 claim free lock 0");
        put(0, 0, 12'h800, 0);           step("R3 reread held lock 0");
        put(1, 0, 12'h800, 0);           step("R3 other port reads held lock 0");
        put(0, 1, 12'h800, 32'h5);       step("R4 nonzero write ignored");
        put(2, 0, 12'h800, 0);           step("R4 still held after nonzero write");
        put(0, 1, 12'h800, 0);           step("R4 zero write frees");
        put(1, 0, 12'h800, 0);           step("R2 reclaim by port1");

        put(0, 0, 12'h8FC, 0);           step("R5 top lock 63");
        put(0, 0, 12'h817, 0);           step("R5 low address bits ignored, lock 5");
        put(1, 0, 12'h814, 0);           step("R5 lock 5 alias held");

        put(2, 0, 12'h014, 0);           step("R6 size word");
        put(0, 1, 12'h014, 0);
        put(1, 0, 12'h016, 0);           step("R6 write ignored, alias read");

        put(0, 0, 12'h81C, 0);
        put(1, 0, 12'h81C, 0);
        put(2, 0, 12'h81C, 0);           step("R7 three-way race lock 7");
        put(0, 0, 12'h010, 0);
        put(1, 0, 12'h824, 0);
        put(2, 0, 12'h824, 0);           step("R7 race lock 9 port1 wins");

        put(0, 0, 12'h900, 0);           step("R8 index 64 reads zero");
        put(1, 0, 12'h900, 0);           step("R8 index 64 no claim");
        put(2, 0, 12'hBFC, 0);
        put(0, 1, 12'h900, 0);           step("R8 index 255 and out-of-bank write");

        put(0, 0, 12'h000, 0);
        put(1, 0, 12'h7FC, 0);
        put(2, 0, 12'hC00, 0);           step("R9 unmapped reads");
        put(0, 1, 12'h000, 0);
        put(1, 1, 12'hC04, 0);
        put(2, 1, 12'h7FC, 32'hFFFF);    step("R9 unmapped writes");

        put(0, 1, 12'h800, 0);
        put(1, 0, 12'h800, 0);
        put(2, 0, 12'h80C, 0);           step("R11 release races read, claim lock 3");
        put(0, 0, 12'h800, 0);           step("R11 lock 0 free after race");

        for (int n = 0; n < 400; n++) begin
            for (int p = 0; p < NP; p++) begin
                int sel = int'($urandom % 8);
                logic [AW-1:0] a;
                logic [DW-1:0] d = ($urandom % 3 == 0) ? DW'($urandom) : '0;
                if (sel < 5)       a = AW'('h800 + 4 * int'($urandom % 4));
                else if (sel == 5) a = 12'h8FC;
                else if (sel == 6) a = 12'h014;
                else               a = 12'h904;
                if ($urandom % 4 != 0) put(p, ($urandom % 3 == 0), a, d);
            end
            step("R7 R11 random mix");
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule